// File: doc/BRIEF.md
# Inverse Square Root Seed Generator

This block produces the starting value for a Newton iteration that converges on one over the square root of an unsigned fraction. The N-bit input is read as a binary fraction with the point to the left of the top bit. The block finds the leading one of that fraction and places a single one in an integer seed at a bit position derived from half the leading-one exponent. The seed is therefore always a power of two. It is close enough to the true inverse square root that the first Newton step starts with a relative error of at most one half.

The logic is purely combinational. A top-down priority scan with a "placed" flag chain marks the leading one. A fixed mapping then folds each pair of adjacent input positions onto one seed bit. An all-zero input has no inverse square root: it yields a zero seed with the valid output low, and whatever consumes the seed has to deal with that case.

Top module: `isr_seed_gen`

## Requirements
- R1: The input bit at index k (0 = least significant) has weight 2^-(N-k), and the seed is an unsigned integer of W = floor((N+1)/2) bits with no fraction bits (W = 8 for the default N = 16).
- R2: When the most significant one of x is at index k, so that p = N-k and 2^-p <= x < 2^-(p-1), the seed bit at index floor((p-1)/2) is set, giving seed = 2^floor((p-1)/2).
- R3: For any nonzero x, exactly one seed bit is set.
- R4: Input bits below the leading one have no effect on the seed. Any pattern below a fixed leading one yields the same seed.
- R5: An all-zero input drives seed to zero and valid to 0.
- R6: valid is 1 for every nonzero input.
- R7: For every nonzero x, 0.25 <= seed^2 * x <= 1, which is equivalent to 0.5 <= seed*sqrt(x) <= 1.
- R8: The outputs depend only on the present input. There is no clock and no state, and a new input shows at the outputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x | input | N | Unsigned fraction 0.x[N-1]...x[0] |
| seed | output | W | Power-of-two seed, integer, W = floor((N+1)/2) |
| valid | output | 1 | High when x is nonzero and the seed is meaningful |

## Verification
The block holds no state. A wrong internal value therefore shows at the ports in the same evaluation as the input that exposes it, and never later. A broken flag in the priority chain lets a lower one leak through, which sets a second seed bit or moves the seed. A wrong pairing in the mapping moves the seed by one position, and the product bound of R7 then fails by a factor of four. An exhaustive sweep of one even and one odd input width reaches every leading-one position and every pattern of lower bits.

// File: rtl/isr_seed_pkg.sv
// Package isr_seed_pkg
// Shared sizing helpers for the inverse square root seed generator.
// Assumes the input width is at least 2.
package isr_seed_pkg;

    // Width of the integer seed for an n-bit fraction input.
    function automatic int seed_width(input int n);
        return (n + 1) / 2;
    endfunction

    // Seed bit index for a leading one at input index k of an n-bit fraction.
    function automatic int seed_index(input int n, input int k);
        return (n - k - 1) / 2;
    endfunction

endpackage

// File: rtl/isr_lead_scan.sv
// Module isr_lead_scan
// Priority scan from the top input bit downward. It marks only the first one
// found. A "placed" flag travels down the chain so that no lower bit can mark
// itself once a one has been taken. Purely combinational.
// Assumes N >= 2.
module isr_lead_scan #(
    parameter int N = 16
) (
    input  logic [N-1:0] x,
    output logic [N-1:0] lead,
    output logic         found
);

    // placed[k] is high when some bit at index k or above is one.
    logic [N:0] placed;

    assign placed[N] = 1'b0;

    genvar k;
    generate
        for (k = N - 1; k >= 0; k--) begin : g_scan
            // Mark bit k only if nothing above it was already taken.
            assign lead[k]   = x[k] & ~placed[k+1];
            // Carry the placed flag down to the next lower position.
            assign placed[k] = placed[k+1] | x[k];
        end
    endgenerate

    // Any one seen anywhere means a seed bit will be placed.
    assign found = placed[0];

endmodule

// File: rtl/isr_seed_map.sv
// Module isr_seed_map
// Folds a one-hot leading-one vector onto the seed. Seed bit j collects the
// input positions whose exponent p = N-k satisfies floor((p-1)/2) == j, that
// is k = N-1-2j and k = N-2-2j. Assumes lead is one-hot or zero.
module isr_seed_map
    import isr_seed_pkg::*;
#(
    parameter int N = 16,
    parameter int W = seed_width(N)
) (
    input  logic [N-1:0] lead,
    output logic [W-1:0] seed
);

    localparam int TOP = N - 1;

    genvar j;
    generate
        for (j = 0; j < W; j++) begin : g_map
            localparam int KHI = TOP - 2 * j;
            localparam int KLO = TOP - 2 * j - 1;
            if (KLO >= 0) begin : g_pair
                // Two exponents share this seed bit.
                assign seed[j] = lead[KHI] | lead[KLO];
            end else begin : g_single
                // Odd N: the bottom seed bit has one source only.
                assign seed[j] = lead[KHI];
            end
        end
    endgenerate

endmodule

// File: rtl/isr_seed_gen.sv
// Module isr_seed_gen
// Top level of the inverse square root seed generator. It takes an N-bit
// unsigned fraction and returns a power-of-two integer seed of
// floor((N+1)/2) bits, with valid low for a zero input.
// Combinational: no clock, no reset, no state. Assumes N >= 2.
module isr_seed_gen
    import isr_seed_pkg::*;
#(
    parameter int N = 16,
    parameter int W = seed_width(N)
) (
    input  logic [N-1:0] x,
    output logic [W-1:0] seed,
    output logic         valid
);

    logic [N-1:0] lead;
    logic         found;

    // Locate the leading one of the fraction.
    isr_lead_scan #(.N(N)) u_scan (
        .x     (x),
        .lead  (lead),
        .found (found)
    );

    // Turn that position into the half-exponent seed bit.
    isr_seed_map #(.N(N), .W(W)) u_map (
        .lead (lead),
        .seed (seed)
    );

    // The seed is meaningful only when a one was found.
    assign valid = found;

endmodule

// File: rtl/isr_seed_gen_chk.sv
// Module isr_seed_gen_chk
// Assertion checker for isr_seed_gen, attached through bind. The block has no
// clock, so every check is an immediate assertion evaluated when the input or
// the outputs change. Checks are skipped while the input is unknown.
module isr_seed_gen_chk
    import isr_seed_pkg::*;
#(
    parameter int N = 16,
    parameter int W = seed_width(N)
) (
    input logic [N-1:0] x,
    input logic [W-1:0] seed,
    input logic         valid
);

    localparam logic [63:0] LOW_BOUND  = 64'd1 << (N - 2);
    localparam logic [63:0] HIGH_BOUND = 64'd1 << N;

    logic [63:0] prod;

    // seed^2 * x as an integer scaled by 2^N.
    assign prod = 64'(seed) * 64'(seed) * 64'(x);

    // Checks that relate the input fraction to the seed outputs.
    always_comb begin
        if (!$isunknown(x)) begin
            assert_onehot_seed_R3: assert ($onehot0(seed) && ((x == '0) || (seed != '0)))
                else $error("seed not one-hot for nonzero x");
            assert_valid_nonzero_R6: assert (valid == (x != '0))
                else $error("valid disagrees with input");
            assert_zero_input_R5: assert (valid || (seed == '0))
                else $error("seed set while invalid");
            assert_product_bound_R7: assert ((x == '0) || ((prod >= LOW_BOUND) && (prod <= HIGH_BOUND)))
                else $error("seed^2*x outside [1/4,1]");
        end
    end

endmodule

bind isr_seed_gen isr_seed_gen_chk #(.N(N), .W(W)) u_chk (
    .x     (x),
    .seed  (seed),
    .valid (valid)
);

// File: tb/tb_isr_seed_gen.sv
// Directed bench for isr_seed_gen. It runs one instance at N=16 and one at N=7
// and checks both against the requirements.
module tb_isr_seed_gen;

    localparam int NA = 16;
    localparam int WA = (NA + 1) / 2;
    localparam int NB = 7;
    localparam int WB = (NB + 1) / 2;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [NA-1:0] xa = '0;
    logic [WA-1:0] seed_a;
    logic          valid_a;
    logic [NB-1:0] xb = '0;
    logic [WB-1:0] seed_b;
    logic          valid_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    isr_seed_gen #(.N(NA)) dut (.x(xa), .seed(seed_a), .valid(valid_a));
    isr_seed_gen #(.N(NB)) dut_odd (.x(xb), .seed(seed_b), .valid(valid_b));

    // Expected seed from the requirement formula: leading one at k, p = n-k.
    function automatic longint exp_seed(input int n, input longint v);
        for (int k = n - 1; k >= 0; k--) begin
            if (v[k]) begin
                return longint'(1) << ((n - k - 1) / 2);
            end
        end
        return 0;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Apply one input to each instance at a posedge, then sample at the negedge.
    task automatic apply(input longint va, input longint vb);
        @(posedge clk);
        xa <= va[NA-1:0];
        xb <= vb[NB-1:0];
        @(negedge clk);
    endtask

    // R5: the idle state (zero input) gives a zero seed and valid low.
    task automatic t_zero;
        apply(0, 0);
        check("R5 seed", longint'(seed_a), 0);
        check("R5 valid", longint'(valid_a), 0);
        check("R5 odd seed", longint'(seed_b), 0);
        check("R5 odd valid", longint'(valid_b), 0);
    endtask

    // R1 R2: a single set bit at each position lands on its half-exponent bit.
    task automatic t_single_bits;
        for (int k = 0; k < NA; k++) begin
            apply(longint'(1) << k, longint'(1) << (k % NB));
            check("R2 single bit", longint'(seed_a), longint'(1) << ((NA - k - 1) / 2));
            check("R1 odd single bit", longint'(seed_b), longint'(1) << ((NB - (k % NB) - 1) / 2));
        end
        // Boundaries: top bit -> seed 1, bottom bit -> top seed bit.
        apply(longint'(1) << (NA - 1), 1);
        check("R2 top bit", longint'(seed_a), 1);
        check("R1 odd bottom bit", longint'(seed_b), longint'(1) << (WB - 1));
        apply(1, longint'(1) << (NB - 1));
        check("R1 bottom bit", longint'(seed_a), longint'(1) << (WA - 1));
        check("R2 odd top bit", longint'(seed_b), 1);
    endtask

    // R4: lower bits beneath a fixed leading one leave the seed unchanged.
    task automatic t_lower_ignored;
        longint base;
        base = longint'(1) << 11;
        for (int m = 0; m < 2048; m += 97) begin
            apply(base | longint'(m), 0);
            check("R4 lower bits", longint'(seed_a), longint'(1) << 2);
        end
        apply(longint'(16'hFFFF), longint'(7'h7F));
        check("R4 all ones", longint'(seed_a), 1);
        check("R4 odd all ones", longint'(seed_b), 1);
    endtask

    // R3 R6 R7 R8: exhaustive sweep, one new input per cycle with no extra edge.
    task automatic t_sweep;
        for (int v = 0; v < (1 << NA); v++) begin
            longint e;
            longint eb;
            longint prod;
            apply(longint'(v), longint'(v % (1 << NB)));
            e = exp_seed(NA, longint'(v));
            check("R8 sweep seed", longint'(seed_a), e);
            if (v != 0) begin
                check("R6 sweep valid", longint'(valid_a), 1);
                check("R3 onehot", longint'($countones(seed_a)), 1);
                prod = longint'(seed_a) * longint'(seed_a) * longint'(v);
                check("R7 bound", longint'((prod >= (longint'(1) << (NA - 2))) && (prod <= (longint'(1) << NA))), 1);
            end
            if (v < (1 << NB)) begin
                eb = exp_seed(NB, longint'(v));
                check("R2 odd sweep", longint'(seed_b), eb);
                check("R6 odd valid", longint'(valid_b), longint'(v != 0));
            end
        end
    endtask

    initial begin
        t_zero();
        t_single_bits();
        t_lower_ignored();
        t_sweep();
        t_zero();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule